// File: doc/BRIEF.md
# Maintenance Request Range Splitter

This block takes one cache maintenance request over a byte range, whose end address is exclusive, and turns it into a stream of hardware range commands. Each range command names the first line and the last line it covers, so its end is inclusive. A range command covers at most 1024 bytes and never crosses a 4096-byte page. There are three request kinds: invalidate, clean and flush. An invalidate request whose first or last line is only partly covered does not drop that line. It cleans and invalidates the line as a single-line command. A write-through override input, sampled when the request is accepted, removes the cleaning work, because a write-through cache holds no dirty data.

Requests arrive on a valid/ready port and commands leave on a second valid/ready port. When the last command has been accepted, a one-cycle done pulse stands for the closing barrier. Executing the commands is left to a downstream engine.

The controller has six states. ST_IDLE waits for a request. ST_HEAD issues the partial first line. ST_TAIL issues the partial last line. ST_FIRST issues the first command of a chunk. ST_SECOND issues the invalidate that follows a clean in flush mode. ST_DONE raises done.

Every state moves only when its command is accepted. The transitions are:
- ST_IDLE goes to ST_DONE for an empty request, and otherwise to ST_HEAD, ST_TAIL or ST_FIRST.
- ST_HEAD goes to ST_TAIL, ST_FIRST or ST_DONE.
- ST_TAIL goes to ST_FIRST or ST_DONE.
- ST_FIRST goes to ST_SECOND when a flush pairs its commands, and otherwise stays in ST_FIRST for the next chunk or goes to ST_DONE.
- ST_SECOND goes to ST_FIRST or ST_DONE.
- ST_DONE always returns to ST_IDLE after one cycle.

Top module: `mrs_splitter`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and done is 0.
- R2: A request is accepted only in the idle state. req_ready stays 0 from the cycle after acceptance until the cycle after done, and req_valid has no effect while the block is busy.
- R3: For clean (req_op 1) and flush (req_op 2), the start is rounded down and the end is rounded up to 32-byte line boundaries before the range is split.
- R4: A range command (cmd_op 0 for clean range, 1 for invalidate range) has a line-aligned cmd_start. Its cmd_end is the address of the last line, which is the chunk end minus 32. A chunk covers at most 1024 bytes.
- R5: The start and end of a range command lie in the same 4096-byte page. A chunk ends at the earliest of three addresses: the request end, start plus 1024, and the next page boundary.
- R6: For invalidate (req_op 0) with an unaligned start, the first command is a single-line clean+invalidate (cmd_op 2, cmd_start equal to cmd_end, both the line address). The start then moves up to the next line boundary.
- R7: For invalidate, if the adjusted start is still below the end and the end is unaligned, the next command is a single-line clean+invalidate on the line holding the end. The end is then rounded down.
- R8: For flush with the override clear, each chunk emits a clean range and then an invalidate range over the same lines.
- R9: With wt_override set at acceptance, a clean request emits no command, and a flush request emits only invalidate range commands.
- R10: done is high for exactly one cycle, the cycle after the last command is accepted. An empty request (start not below end, or req_op 3) emits no command and raises done the cycle after acceptance.
- R11: While cmd_valid is high and cmd_ready is low, cmd_op, cmd_start and cmd_end hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_override | input | 1 | Write-through override, sampled on request acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no operation |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | Byte after the last byte of the range |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by the engine |
| cmd_op | output | 2 | 0 clean range, 1 invalidate range, 2 clean+invalidate single line |
| cmd_start | output | ADDR_W | First line address, inclusive |
| cmd_end | output | ADDR_W | Last line address, inclusive |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases, and each one exposes a specific kind of bug:
- An invalidate whose start and end fall in the same line. A wrong tail condition would issue that line twice.
- An invalidate with an aligned start and an unaligned end in the same line. Dropping the tail here would leave stale data in the cache.
- Ranges that run across a page boundary, and ranges longer than 1024 bytes. A missing clip would show up as a command whose end lies in the next page or more than 992 bytes past its start.
- Flush and clean with and without the override. These catch a lost or misplaced clean command, and cleaning that should have been suppressed.
- Empty requests and reserved opcodes. These catch a block that emits commands it should not, or that never raises done.
- Random backpressure, and a second request held on the input while the block is busy. These catch commands that change while stalled, and requests taken in the middle of a stream.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [1:0] {
        REQ_INV   = 2'd0,
        REQ_CLEAN = 2'd1,
        REQ_FLUSH = 2'd2,
        REQ_NONE  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        CMD_CLEAN_RANGE = 2'd0,
        CMD_INV_RANGE   = 2'd1,
        CMD_CLINV_LINE  = 2'd2,
        CMD_RSVD        = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL,
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } state_e;

endpackage

// File: rtl/mrs_req_norm.sv
// Aligns a fresh request to line boundaries and decides which edge lines need
// single-line treatment.
module mrs_req_norm #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    input  logic              wt,
    output logic              empty,
    output logic              head,
    output logic              tail,
    output logic [ADDR_W-1:0] cur0,
    output logic [ADDR_W-1:0] end0
);
    import mrs_pkg::*;

    localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] start_dn, start_up, stop_dn, stop_up;
    logic              start_un, stop_un;

    always_comb begin
        start_dn = start_addr & ~LMASK;
        start_up = (start_addr | LMASK) + ADDR_W'(1);
        stop_dn  = stop_addr & ~LMASK;
        stop_up  = (stop_addr + LMASK) & ~LMASK;
        start_un = |(start_addr & LMASK);
        stop_un  = |(stop_addr & LMASK);

        empty = (kind == REQ_NONE) || (start_addr >= stop_addr) ||
                ((kind == REQ_CLEAN) && wt);
        head  = 1'b0;
        tail  = 1'b0;
        cur0  = start_dn;
        end0  = stop_up;

        if (kind == REQ_INV) begin
            head = start_un;
            cur0 = start_un ? start_up : start_addr;
            tail = (cur0 < stop_addr) && stop_un;
            end0 = tail ? stop_dn : stop_addr;
        end

        if (empty) begin
            head = 1'b0;
            tail = 1'b0;
        end
    end

endmodule

// File: rtl/mrs_chunk.sv
// Exclusive end of the next chunk: the earliest of the request end, the size
// cap and the next page boundary.
module mrs_chunk #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] lim,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] PMASK = ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] CAP   = ADDR_W'(CHUNK_BYTES);

    logic [ADDR_W-1:0] cap_end, page_end;

    always_comb begin
        cap_end  = cur + CAP;
        page_end = (cur | PMASK) + ADDR_W'(1);
        nxt      = lim;
        if (nxt > cap_end)  nxt = cap_end;
        if (nxt > page_end) nxt = page_end;
    end

endmodule

// File: rtl/mrs_splitter.sv
module mrs_splitter #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_override,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_start,
    output logic [ADDR_W-1:0] cmd_end,
    output logic              done
);
    import mrs_pkg::*;

    localparam logic [ADDR_W-1:0] LINE = ADDR_W'(LINE_BYTES);

    state_e            state_q, state_d;
    logic [1:0]        kind_q;
    logic              wt_q, tail_q;
    logic [ADDR_W-1:0] cur_q, end_q;

    logic              n_empty, n_head, n_tail;
    logic [ADDR_W-1:0] n_cur, n_end, chunk_end;
    logic              pair, last_chunk, take_req;

    mrs_req_norm #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_norm (
        .kind       (req_op),
        .start_addr (req_start),
        .stop_addr  (req_end),
        .wt         (wt_override),
        .empty      (n_empty),
        .head       (n_head),
        .tail       (n_tail),
        .cur0       (n_cur),
        .end0       (n_end)
    );

    mrs_chunk #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .cur (cur_q),
        .lim (end_q),
        .nxt (chunk_end)
    );

    assign pair       = (kind_q == REQ_FLUSH) && !wt_q;
    assign last_chunk = (chunk_end >= end_q);
    assign take_req   = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (n_empty)     state_d = ST_DONE;
                    else if (n_head) state_d = ST_HEAD;
                    else if (n_tail) state_d = ST_TAIL;
                    else             state_d = ST_FIRST;
                end
            end
            ST_HEAD: begin
                if (cmd_ready) begin
                    if (tail_q)             state_d = ST_TAIL;
                    else if (cur_q < end_q) state_d = ST_FIRST;
                    else                    state_d = ST_DONE;
                end
            end
            ST_TAIL: begin
                if (cmd_ready) state_d = (cur_q < end_q) ? ST_FIRST : ST_DONE;
            end
            ST_FIRST: begin
                if (cmd_ready) begin
                    if (pair)            state_d = ST_SECOND;
                    else if (last_chunk) state_d = ST_DONE;
                    else                 state_d = ST_FIRST;
                end
            end
            ST_SECOND: begin
                if (cmd_ready) state_d = last_chunk ? ST_DONE : ST_FIRST;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working range registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= 2'd0;
            wt_q   <= 1'b0;
            tail_q <= 1'b0;
            cur_q  <= '0;
            end_q  <= '0;
        end else if (take_req) begin
            kind_q <= req_op;
            wt_q   <= wt_override;
            tail_q <= n_tail;
            cur_q  <= n_cur;
            end_q  <= n_end;
        end else if (cmd_ready &&
                     (((state_q == ST_FIRST) && !pair) || (state_q == ST_SECOND))) begin
            cur_q <= chunk_end;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = CMD_INV_RANGE;
        cmd_start = cur_q;
        cmd_end   = chunk_end - LINE;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_HEAD: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_CLINV_LINE;
                cmd_start = cur_q - LINE;
                cmd_end   = cur_q - LINE;
            end
            ST_TAIL: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_CLINV_LINE;
                cmd_start = end_q;
                cmd_end   = end_q;
            end
            ST_FIRST: begin
                cmd_valid = 1'b1;
                cmd_op    = ((kind_q == REQ_CLEAN) || pair) ? CMD_CLEAN_RANGE : CMD_INV_RANGE;
            end
            ST_SECOND: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_INV_RANGE;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mrs_splitter_chk.sv
module mrs_splitter_chk #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wt_override,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_start,
    input logic [ADDR_W-1:0] req_end,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_start,
    input logic [ADDR_W-1:0] cmd_end,
    input logic              done
);
    localparam int LINE_BITS = $clog2(LINE_BYTES);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] MAX_SPAN = ADDR_W'(CHUNK_BYTES - LINE_BYTES);

    logic       wt_seen;
    logic [1:0] op_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_seen <= 1'b0;
            op_seen <= 2'd3;
        end else if (req_valid && req_ready) begin
            wt_seen <= wt_override;
            op_seen <= req_op;
        end
    end

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || done) |-> !req_ready) else $error("busy accepts"); // R2

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_start[LINE_BITS-1:0] == '0) && (cmd_end[LINE_BITS-1:0] == '0))
        else $error("unaligned command"); // R4

    AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_end >= cmd_start) && ((cmd_end - cmd_start) <= MAX_SPAN))
        else $error("chunk too large"); // R4

    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_start[ADDR_W-1:PAGE_BITS] == cmd_end[ADDR_W-1:PAGE_BITS]))
        else $error("page crossed"); // R5

    AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> (cmd_start == cmd_end))
        else $error("line op spans"); // R6

    AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd0 && op_seen == 2'd2) |=>
        (cmd_valid && cmd_op == 2'd1 && $stable(cmd_start) && $stable(cmd_end)))
        else $error("flush pair broken"); // R8

    AST_WT_NO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && wt_seen) |-> (cmd_op != 2'd0)) else $error("clean under override"); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done too long"); // R10

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
        (cmd_valid && $stable(cmd_op) && $stable(cmd_start) && $stable(cmd_end)))
        else $error("command moved while stalled"); // R11

endmodule

bind mrs_splitter mrs_splitter_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (.*);

// File: tb/tb_mrs_splitter.sv
module tb_mrs_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wt_override = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_start = '0, req_end = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_start, cmd_end;
    logic          done;

    int total = 0;
    int bad = 0;
    bit timed_out = 1'b0;

    logic [1:0]    e_op [64];
    logic [AW-1:0] e_s  [64];
    logic [AW-1:0] e_e  [64];
    int            n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrs_splitter dut (
        .clk(clk), .rst_n(rst_n), .wt_override(wt_override),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_start(req_start), .req_end(req_end),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] op, input logic [AW-1:0] s, input logic [AW-1:0] e);
        e_op[n_exp] = op;
        e_s[n_exp]  = s;
        e_e[n_exp]  = e;
        n_exp++;
    endtask

    function automatic logic [AW-1:0] chunk_of(input logic [AW-1:0] s, input logic [AW-1:0] e);
        logic [AW-1:0] r;
        r = e;
        if (r > s + 32'd1024) r = s + 32'd1024;
        if (r > ((s | 32'hFFF) + 32'd1)) r = (s | 32'hFFF) + 32'd1;
        return r;
    endfunction

    task automatic build_exp(input logic [1:0] op, input logic [AW-1:0] s0,
                             input logic [AW-1:0] e0, input bit wt);
        logic [AW-1:0] s, e, r;
        s = s0;
        e = e0;
        n_exp = 0;
        if (op == 2'd3 || s >= e) return;
        if (op == 2'd0) begin
            if (s[4:0] != 0) begin
                push(2'd2, s & ~32'h1F, s & ~32'h1F);
                s = (s | 32'h1F) + 32'd1;
            end
            if (s < e && e[4:0] != 0) begin
                push(2'd2, e & ~32'h1F, e & ~32'h1F);
                e = e & ~32'h1F;
            end
            while (s < e) begin
                r = chunk_of(s, e);
                push(2'd1, s, r - 32'd32);
                s = r;
            end
        end else begin
            if (op == 2'd1 && wt) return;
            s = s & ~32'h1F;
            e = (e + 32'h1F) & ~32'h1F;
            while (s < e) begin
                r = chunk_of(s, e);
                if (op == 2'd1 || !wt) push(2'd0, s, r - 32'd32);
                if (op == 2'd2) push(2'd1, s, r - 32'd32);
                s = r;
            end
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [AW-1:0] s, input logic [AW-1:0] e,
                           input bit wt, input string tag);
        int idx;
        int cyc;
        bit busy_ok;
        build_exp(op, s, e, wt);
        @(negedge clk);
        req_valid   = 1'b1;
        req_op      = op;
        req_start   = s;
        req_end     = e;
        wt_override = wt;
        @(negedge clk);
        // keep a junk request pending: it must be ignored while busy (R2)
        req_op    = 2'd2;
        req_start = 32'h0000_0000;
        req_end   = 32'h0000_8000;
        idx = 0;
        cyc = 0;
        busy_ok = 1'b1;
        forever begin
            cmd_ready = ($urandom % 10) < 7;
            #1;
            if (req_ready) busy_ok = 1'b0;
            if (done) begin
                chk(idx == n_exp, {tag, " R10 done after last cmd"}, 96'(idx), 96'(n_exp));
                req_valid = 1'b0;
                break;
            end
            if (cmd_valid && cmd_ready) begin
                if (idx < n_exp)
                    chk(cmd_op == e_op[idx] && cmd_start == e_s[idx] && cmd_end == e_e[idx],
                        {tag, " R4 command"}, {30'd0, cmd_op, cmd_start, cmd_end},
                        {30'd0, e_op[idx], e_s[idx], e_e[idx]});
                else
                    chk(1'b0, {tag, " R10 extra command"}, 96'(idx), 96'(n_exp));
                idx++;
            end
            cyc++;
            if (cyc > 2000) begin
                timed_out = 1'b1;
                chk(1'b0, {tag, " watchdog"}, 96'(cyc), 96'(0));
                req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
        chk(busy_ok, {tag, " R2 req_ready low while busy"}, 96'(busy_ok), 96'(1));
        cmd_ready = 1'b0;
        @(negedge clk);
        #1;
        chk(req_ready && !done, {tag, " R2 idle after done"}, 96'({req_ready, done}), 96'(2));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 reset state",
            96'({req_ready, cmd_valid, done}), 96'(3'b100));
        rst_n = 1'b1;

        run_req(2'd0, 32'h0000_1004, 32'h0000_1C10, 1'b0, "R6 R7 inv head tail multi");
        run_req(2'd0, 32'h0000_2005, 32'h0000_2010, 1'b0, "R6 inv same line head only");
        run_req(2'd0, 32'h0000_3000, 32'h0000_3010, 1'b0, "R7 inv tail only");
        run_req(2'd0, 32'h0000_3FE0, 32'h0000_4420, 1'b0, "R5 inv page cross");
        run_req(2'd1, 32'h0000_0F03, 32'h0000_1301, 1'b0, "R3 R5 clean page cross");
        run_req(2'd1, 32'h0000_4000, 32'h0000_5000, 1'b0, "R4 clean 1024 cap");
        run_req(2'd2, 32'h0000_6010, 32'h0000_6C05, 1'b0, "R8 flush pairs");
        run_req(2'd2, 32'h0000_6010, 32'h0000_6C05, 1'b1, "R9 flush override");
        run_req(2'd1, 32'h0000_7000, 32'h0000_7400, 1'b1, "R9 clean override");
        run_req(2'd0, 32'h0000_8000, 32'h0000_8000, 1'b0, "R10 empty");
        run_req(2'd2, 32'h0000_9000, 32'h0000_8000, 1'b0, "R10 reversed");
        run_req(2'd3, 32'h0000_A000, 32'h0000_B000, 1'b0, "R10 reserved op");

        for (int i = 0; i < 300 && !timed_out; i++) begin
            logic [AW-1:0] s;
            logic [AW-1:0] len;
            s   = $urandom & 32'h0FFF_FFFF;
            len = $urandom % 6000;
            if (($urandom % 16) == 0) len = 0;
            run_req(2'($urandom % 4), s, s + len, 1'($urandom % 2), "R11 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog global actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule